// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Power-Up Initialisation

This block owns the refresh duty of a DRAM controller. Out of reset it keeps both strobes idle through a long power-up wait. It then runs a fixed burst of refresh cycles on its own before it raises a ready flag. Only after that flag is high may the controller start accesses. Every refresh uses the CAS-before-RAS method: the device advances its internal row counter, so no address is driven. The address, write-enable and output-enable lines, and the data bus, are don't-care during the cycle. All strobe widths are parameters counted in clock cycles.

In normal operation an interval timer posts one refresh request per period. The period is short for the standard part and long for the low-power part, picked by an input. The requests pile up in a saturating pending counter, so the controller may put a refresh off while a page is open. When the backlog reaches a threshold, an urgent flag tells the controller to close its page. The controller grants a refresh when it has released the strobes.

A refresh may also be hidden behind a read. In that case CAS stays low for the whole cycle, which keeps the read data on the bus, and RAS is cycled high and then low again.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset `ready_o` is 0, `ras_n_o` and `cas_n_o` are 1, and `req_o` is 0. No strobe falls until at least `INIT_DELAY_CYC` cycles after reset is released.
- R2: After the wait the block runs exactly `INIT_REFRESHES` refresh cycles without any grant. It then raises `ready_o`, which stays 1 until the next reset. These refreshes leave `pending_o` at 0.
- R3: In a normal refresh, `cas_n_o` is 0 for exactly `CSR_CYC` cycles before `ras_n_o` falls. It stays 0 for exactly `CHR_CYC` cycles while `ras_n_o` is low, and it rises before `ras_n_o` does.
- R4: `ras_n_o` stays low for exactly `RAS_CYC` cycles per refresh. Between two refreshes `ras_n_o` is high for at least `RP_CYC` cycles.
- R5: Once ready, one request is added every `SHORT_CYC` cycles while `long_period_i`=0, and every `LONG_CYC` cycles while it is 1. The first request comes `SHORT_CYC` cycles after `ready_o` rises.
- R6: `pending_o` saturates at `PEND_MAX` and further requests are dropped. Each granted refresh lowers it by exactly one.
- R7: `req_o` is 1 exactly when `pending_o` is nonzero. `urgent_o` is 1 exactly when `pending_o` is at least `URGENT_TH`.
- R8: A refresh starts only on a cycle where `grant_i`=1, `req_o`=1 and `busy_o`=0. A grant while nothing is pending is ignored: the strobes stay high and `busy_o` stays 0.
- R9: If `hidden_i`=1 on the granting cycle, `cas_n_o` is low with `ras_n_o` high for `RP_CYC` cycles. Then `ras_n_o` is low for `RAS_CYC` cycles with `cas_n_o` held low throughout, and both strobes go high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| long_period_i | input | 1 | 1 selects the long (low-power) request interval |
| grant_i | input | 1 | Controller has released the strobes for a refresh |
| hidden_i | input | 1 | Granted refresh is hidden behind a read (CAS held low) |
| ready_o | output | 1 | Initialisation done; accesses allowed |
| req_o | output | 1 | At least one refresh pending |
| urgent_o | output | 1 | Backlog at or above threshold; close the page |
| pending_o | output | $clog2(PEND_MAX+1) | Pending refresh count |
| busy_o | output | 1 | Refresh sequence owns the strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |

## Verification
The request timer is tried in both interval modes, including a switch just after a request is posted. This shows whether the limit follows the mode input or is latched. The pending counter is first filled past its limit with no grants, which exposes wrap-around and threshold errors. It is then drained with alternating normal and hidden refreshes. A scoreboard measures each strobe waveform against the expected kind of refresh, so it can tell the two sequences apart and catch a wrong phase length. A grant with nothing pending, and the burst count before ready, separate request gating from the forced initial refreshes.

// File: rtl/drfsh_pkg.sv
package drfsh_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CSR,   // CAS low, RAS high, ahead of RAS fall
    PH_HPRE,  // hidden: CAS held low, RAS precharge
    PH_ACT,   // RAS low
    PH_PRE    // both high, precharge
  } phase_e;

  typedef enum logic [1:0] {
    ST_WAIT,
    ST_BURST,
    ST_RUN
  } init_e;
endpackage

// File: rtl/drfsh_seq.sv
module drfsh_seq
  import drfsh_pkg::*;
#(
  parameter int CSR_CYC = 2,
  parameter int CHR_CYC = 5,
  parameter int RAS_CYC = 9,
  parameter int RP_CYC  = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic hidden_i,
  output logic busy_o,
  output logic done_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int MAXL0 = (CSR_CYC > RAS_CYC) ? CSR_CYC : RAS_CYC;
  localparam int MAXL  = (MAXL0 > RP_CYC) ? MAXL0 : RP_CYC;
  localparam int CW    = $clog2(MAXL + 1);
  localparam logic [CW-1:0] CSR_LAST = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] RAS_LAST = CW'(RAS_CYC - 1);
  localparam logic [CW-1:0] RP_LAST  = CW'(RP_CYC - 1);
  localparam logic [CW-1:0] CHR_LIM  = CW'(CHR_CYC);

  phase_e          phase_q;
  logic [CW-1:0]   cnt_q;
  logic            hid_q;
  logic [CW-1:0]   last;
  logic            at_end;

  always_comb begin
    unique case (phase_q)
      PH_CSR:         last = CSR_LAST;
      PH_HPRE, PH_PRE: last = RP_LAST;
      PH_ACT:         last = RAS_LAST;
      default:        last = '0;
    endcase
    at_end = (cnt_q == last);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      hid_q   <= 1'b0;
    end else if (phase_q == PH_IDLE) begin
      if (start_i) begin
        phase_q <= hidden_i ? PH_HPRE : PH_CSR;
        hid_q   <= hidden_i;
        cnt_q   <= '0;
      end
    end else if (at_end) begin
      cnt_q <= '0;
      unique case (phase_q)
        PH_CSR, PH_HPRE: phase_q <= PH_ACT;
        PH_ACT:          phase_q <= PH_PRE;
        default:         phase_q <= PH_IDLE;
      endcase
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o  = (phase_q != PH_IDLE);
  assign done_o  = (phase_q == PH_PRE) && at_end;
  assign ras_n_o = (phase_q != PH_ACT);
  assign cas_n_o = !((phase_q == PH_CSR) || (phase_q == PH_HPRE) ||
                     ((phase_q == PH_ACT) && (hid_q || (cnt_q < CHR_LIM))));

  // checker state: strobe run lengths
  logic [CW:0] lo_run_q, hi_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run_q <= '0;
      hi_run_q <= (CW+1)'(RP_CYC);
    end else begin
      lo_run_q <= ras_n_o ? '0 : lo_run_q + 1'b1;
      if (!ras_n_o) hi_run_q <= '0;
      else if (hi_run_q < (CW+1)'(RP_CYC)) hi_run_q <= hi_run_q + 1'b1;
    end
  end

  a_r3_cas_leads_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> ($past(!cas_n_o) && !cas_n_o));
  a_r3_cas_rises_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ras_n_o) && !hid_q) |-> $past(cas_n_o));
  a_r4_ras_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (lo_run_q == (CW+1)'(RAS_CYC)));
  a_r4_precharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (hi_run_q >= (CW+1)'(RP_CYC)));
  a_r9_hidden_cas_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hid_q && !ras_n_o) |=> (ras_n_o || !cas_n_o));
endmodule

// File: rtl/drfsh_tick.sv
module drfsh_tick #(
  parameter int SHORT_CYC = 3120,
  parameter int LONG_CYC  = 25000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic long_i,
  output logic tick_o
);
  localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int TW   = $clog2(MAXC);
  localparam logic [TW-1:0] SHORT_LAST = TW'(SHORT_CYC - 1);
  localparam logic [TW-1:0] LONG_LAST  = TW'(LONG_CYC - 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] lim;

  assign lim    = long_i ? LONG_LAST : SHORT_LAST;
  // >= so a mode switch to the short limit never overruns
  assign tick_o = en_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  a_r5_ticks_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/drfsh_pend.sv
module drfsh_pend #(
  parameter int PEND_MAX  = 7,
  parameter int URGENT_TH = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          inc_i,
  input  logic                          dec_i,
  output logic [$clog2(PEND_MAX+1)-1:0] cnt_o,
  output logic                          req_o,
  output logic                          urgent_o
);
  localparam int PW = $clog2(PEND_MAX + 1);
  localparam logic [PW-1:0] MAXV = PW'(PEND_MAX);
  localparam logic [PW-1:0] THV  = PW'(URGENT_TH);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec_i && cnt_q != MAXV) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign req_o    = (cnt_q != '0);
  assign urgent_o = (cnt_q >= THV);

  a_r6_hold_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAXV && inc_i && !dec_i) |=> (cnt_q == MAXV));
  a_r6_dec_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import drfsh_pkg::*;
#(
  parameter int INIT_DELAY_CYC = 40000,
  parameter int INIT_REFRESHES = 8,
  parameter int SHORT_CYC      = 3120,
  parameter int LONG_CYC       = 25000,
  parameter int CSR_CYC        = 2,
  parameter int CHR_CYC        = 5,
  parameter int RAS_CYC        = 9,
  parameter int RP_CYC         = 9,
  parameter int PEND_MAX       = 7,
  parameter int URGENT_TH      = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          long_period_i,
  input  logic                          grant_i,
  input  logic                          hidden_i,
  output logic                          ready_o,
  output logic                          req_o,
  output logic                          urgent_o,
  output logic [$clog2(PEND_MAX+1)-1:0] pending_o,
  output logic                          busy_o,
  output logic                          ras_n_o,
  output logic                          cas_n_o
);
  localparam int DW = $clog2(INIT_DELAY_CYC + 1);
  localparam int BW = $clog2(INIT_REFRESHES + 1);
  localparam logic [DW-1:0] DLY_LAST   = DW'(INIT_DELAY_CYC - 1);
  localparam logic [BW-1:0] BURST_LAST = BW'(INIT_REFRESHES - 1);

  init_e         st_q;
  logic [DW-1:0] dly_q;
  logic [BW-1:0] burst_q;
  logic          run, tick, seq_start, seq_hidden, seq_busy, seq_done;

  assign run = (st_q == ST_RUN);

  drfsh_pend #(
    .PEND_MAX (PEND_MAX),
    .URGENT_TH(URGENT_TH)
  ) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (tick),
    .dec_i   (seq_done && run),
    .cnt_o   (pending_o),
    .req_o   (req_o),
    .urgent_o(urgent_o)
  );

  drfsh_tick #(
    .SHORT_CYC(SHORT_CYC),
    .LONG_CYC (LONG_CYC)
  ) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (run),
    .long_i(long_period_i),
    .tick_o(tick)
  );

  always_comb begin
    seq_start  = !seq_busy && ((st_q == ST_BURST) || (run && grant_i && req_o));
    seq_hidden = run && hidden_i;
  end

  drfsh_seq #(
    .CSR_CYC(CSR_CYC),
    .CHR_CYC(CHR_CYC),
    .RAS_CYC(RAS_CYC),
    .RP_CYC (RP_CYC)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (seq_start),
    .hidden_i(seq_hidden),
    .busy_o  (seq_busy),
    .done_o  (seq_done),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_WAIT;
      dly_q   <= '0;
      burst_q <= '0;
    end else begin
      unique case (st_q)
        ST_WAIT: begin
          if (dly_q == DLY_LAST) st_q <= ST_BURST;
          else                   dly_q <= dly_q + 1'b1;
        end
        ST_BURST: begin
          if (seq_done) begin
            if (burst_q == BURST_LAST) st_q <= ST_RUN;
            else                       burst_q <= burst_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign ready_o = run;
  assign busy_o  = seq_busy;

  a_r1_quiet_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) |-> (ras_n_o && cas_n_o));
  a_r2_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  a_r8_start_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $rose(busy_o)) |-> $past(grant_i && req_o && ready_o));
endmodule

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;
  localparam int DLY = 50, NINIT = 8, SHORT = 60, LONG = 200;
  localparam int CSR = 2, CHR = 5, RASW = 9, RP = 9, PMAX = 7, TH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic long_p = 1'b0, grant = 1'b0, hidden = 1'b0;
  logic ready, req, urgent, busy, ras_n, cas_n;
  logic [2:0] pend;

  always #2.5 clk = ~clk;

  dram_refresh_sched #(
    .INIT_DELAY_CYC(DLY), .INIT_REFRESHES(NINIT), .SHORT_CYC(SHORT),
    .LONG_CYC(LONG), .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_CYC(RASW),
    .RP_CYC(RP), .PEND_MAX(PMAX), .URGENT_TH(TH)
  ) u_dram_refresh_sched (
    .clk_i(clk), .rst_ni(rst_n), .long_period_i(long_p), .grant_i(grant),
    .hidden_i(hidden), .ready_o(ready), .req_o(req), .urgent_o(urgent),
    .pending_o(pend), .busy_o(busy), .ras_n_o(ras_n), .cas_n_o(cas_n)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit exp_q[$];
  int pushed = 0, popped = 0, init_falls = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string rq, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, expv);
    end
  endtask

  // monitor: measure each strobe waveform and compare to the queued kind
  bit prev_ras = 1'b1;
  int cas_run = 0, hi_run = 1000, lo_run = 0, cin = 0, csr_m = 0, gap_m = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ras_n) begin
        if (prev_ras) begin
          csr_m = cas_run; gap_m = hi_run; lo_run = 0; cin = 0;
          if (!ready) init_falls++;
        end
        lo_run++;
        if (!cas_n) cin++;
      end else begin
        if (!prev_ras) begin
          if (exp_q.size() == 0) chk(0, "R8", "unexpected refresh", 1, 0);
          else begin
            bit h;
            h = exp_q.pop_front();
            popped++;
            if (h) begin
              chk(csr_m == RP, "R9", "hidden cas lead", csr_m, RP);
              chk(cin == RASW, "R9", "hidden cas held", cin, RASW);
              chk(cas_n == 1'b1, "R9", "cas high with ras", cas_n, 1);
            end else begin
              chk(csr_m == CSR, "R3", "cas lead", csr_m, CSR);
              chk(cin == CHR, "R3", "cas hold after ras", cin, CHR);
            end
            chk(lo_run == RASW, "R4", "ras low width", lo_run, RASW);
            chk(gap_m >= RP, "R4", "ras precharge", gap_m, RP);
          end
          hi_run = 0;
        end
        hi_run++;
      end
      cas_run = cas_n ? 0 : cas_run + 1;
      prev_ras = ras_n;
    end
  end

  task automatic wait_up(output int c);
    int p;
    p = pend;
    do @(negedge clk); while (pend <= p);
    c = cyc;
  endtask

  task automatic do_refresh(bit h);
    while (!(req && !busy)) @(negedge clk);
    grant = 1'b1; hidden = h;
    exp_q.push_back(h); pushed++;
    @(negedge clk);
    grant = 1'b0; hidden = 1'b0;
    chk(busy == 1'b1, "R8", "busy after grant", busy, 1);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int rel, c, t_last, p0, guard;
    bit did_dec, quiet;
    repeat (3) @(negedge clk);
    chk(ready == 0, "R1", "ready in reset", ready, 0);
    chk(ras_n && cas_n, "R1", "strobes in reset", {ras_n, cas_n}, 3);
    chk(req == 0, "R1", "req in reset", req, 0);
    for (int i = 0; i < NINIT; i++) begin exp_q.push_back(1'b0); pushed++; end
    rst_n = 1'b1; rel = cyc;
    while (cas_n) @(negedge clk);
    chk((cyc - rel) >= DLY, "R1", "power-up wait", cyc - rel, DLY);
    while (!ready) @(negedge clk);
    chk(init_falls == NINIT, "R2", "init refresh count", init_falls, NINIT);
    chk(pend == 0, "R2", "pending after init", pend, 0);
    t_last = cyc;

    // fill with no grant; one refresh at pending 2
    did_dec = 0;
    for (int k = 0; k < 14 && pend != PMAX; k++) begin
      wait_up(c);
      chk((c - t_last) == SHORT, "R5", "short interval", c - t_last, SHORT);
      t_last = c;
      chk(urgent == (pend >= TH), "R7", "urgent flag", urgent, pend >= TH);
      chk(req == 1, "R7", "req with pending", req, 1);
      if (pend == 2 && !did_dec) begin
        do_refresh(1'b0);
        chk(pend == 1, "R6", "decrement by one", pend, 1);
        did_dec = 1;
      end
    end
    chk(pend == PMAX, "R6", "reach limit", pend, PMAX);
    repeat (2 * SHORT + 3) @(negedge clk);
    chk(pend == PMAX, "R6", "saturated", pend, PMAX);
    chk(urgent == 1, "R7", "urgent at limit", urgent, 1);

    // drain, alternating hidden and normal
    guard = 0;
    while (pend != 0 && guard < 20) begin do_refresh(guard[0]); guard++; end
    chk(req == 0, "R7", "req after drain", req, 0);
    chk(urgent == 0, "R7", "urgent after drain", urgent, 0);

    // grant with nothing pending
    wait_up(c);
    do_refresh(1'b1);
    p0 = pend;
    chk(p0 == 0, "R6", "empty before idle grant", p0, 0);
    grant = 1'b1; quiet = 1;
    repeat (20) begin
      @(negedge clk);
      if (!ras_n || !cas_n || busy) quiet = 0;
    end
    grant = 1'b0;
    chk(quiet, "R8", "idle grant ignored", quiet, 1);

    // long interval, then back to short
    wait_up(c); t_last = c; long_p = 1'b1;
    wait_up(c);
    chk((c - t_last) == LONG, "R5", "long interval", c - t_last, LONG);
    t_last = c; long_p = 1'b0;
    wait_up(c);
    chk((c - t_last) == SHORT, "R5", "short after long", c - t_last, SHORT);

    guard = 0;
    while (pend != 0 && guard < 10) begin do_refresh(1'b1); guard++; end
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0 && popped == pushed, "R8", "all refreshes seen",
        popped, pushed);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule